// File: doc/BRIEF.md
# Rotating-Priority Eight-Line Interrupt Controller

This block collects up to eight interrupt request lines and presents the most urgent unmasked one to a processor. Each line is either edge or level sensitive, selected per line by a static configuration input. The controller holds a request register, a mask register and an in-service register. Priority is resolved against a rotatable base: the line one past the base is the most urgent. The interrupt output is raised only when the best pending unmasked request outranks everything already in service.

Software drives the block through a byte-wide register port with a single address bit. Writing a start byte at address 0 opens an initialisation sequence of three or four bytes. The later bytes set the vector base and the optional mode bits (special fully nested, automatic end of interrupt). After that sequence, bytes at address 1 load the mask. Bytes at address 0 are either control bytes (poll arming, read-back selection, special mask) or operation commands (end-of-interrupt variants and priority rotation). An acknowledge strobe returns an 8-bit vector in the same cycle and commits the service state at the clock edge. A poll read does the same work without an acknowledge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Line (p + base) mod 8 has priority rank p, and rank 0 is the most urgent. The pending line chosen is the lowest-rank set bit of request AND NOT mask.
- R2: `int_out` is high exactly when the chosen pending line has a strictly lower rank than the lowest-rank in-service line, or when a line is pending and nothing is in service.
- R3: A write to address 0 with bit 4 set clears mask, request, in-service, rotation base, vector base, read selection, poll, special mask and all modes. It leaves `int_out` low and waits for the vector-base byte.
- R4: The next address-1 write after the start byte stores the vector base as the byte with bits 2:0 cleared. `vec_out` is the vector base OR the line number (line 7 when nothing is pending).
- R5: The byte after the vector base finishes initialisation, unless bit 0 of the start byte was set. In that case one more address-1 byte follows: its bit 4 enables special fully nested mode and its bit 1 enables automatic end of interrupt.
- R6: Outside initialisation, an address-1 write loads the mask register. A masked line never raises `int_out`.
- R7: A read at address 1 returns the mask. A read at address 0 returns the in-service register if the read selection is 1, and the request register if it is 0. A control byte (address 0, bit 3 set, bit 4 clear) with bit 1 set loads the selection from bit 0.
- R8: On acknowledge with `int_out` high, and with automatic EOI off, the chosen line's in-service bit is set. Its request bit is cleared for an edge line and kept for a level line.
- R9: Command code 1 (bits 7:5 of an address-0 non-control byte) clears the lowest-rank in-service bit. Code 5 does the same and then sets the rotation base to that line + 1.
- R10: Code 3 clears the in-service bit of line bits 2:0. Code 7 does the same and sets the base to that line + 1. Code 6 sets the base to (bits 2:0 + 1) mod 8.
- R11: With automatic EOI on, an acknowledge sets no in-service bit. If rotate-on-auto-EOI is set (codes 0 and 4 load it from bit 7), the base becomes the acknowledged line + 1.
- R12: A control byte with bit 2 set arms a poll. The next read returns the chosen line number, or 0 if `int_out` is low. That read clears the line's request and in-service bits and disarms the poll.
- R13: On the master in special fully nested mode, in-service bit 2 is ignored when computing current priority. With special mask on (control bit 6 enables a load from bit 5), masked in-service lines are ignored as well.
- R14: An edge line sets its request bit on a rising input and clears it whenever the input is low. A level line's request bit follows the input one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | 8 | Interrupt request inputs |
| lvl_mode | input | 8 | Per-line trigger select, 1 = level, 0 = edge |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (commits poll side effects) |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| ack | input | 1 | Interrupt acknowledge strobe |
| vec_out | output | 8 | Vector for the acknowledged line, combinational |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
On every cycle, the checker confirms four things. An initialisation byte leaves mask and in-service empty with the output low. A normal address-1 write lands in the mask. An acknowledge without auto-EOI marks the vector's line in service. A poll read disarms the poll. It also confirms that the output never rises without an unmasked request. Whether the right line wins under each rotation base, and what the vector and read-back values are, can only be shown by the bench's scenarios. The same holds for the EOI and rotation commands, the edge/level differences, and the nested and special-mask exceptions. These scenarios include a sweep over all eight bases and all 255 request patterns.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_e;

  localparam logic [2:0] OP_ROT_AEOI_A = 3'd0;
  localparam logic [2:0] OP_NS_EOI     = 3'd1;
  localparam logic [2:0] OP_SP_EOI     = 3'd3;
  localparam logic [2:0] OP_ROT_AEOI_B = 3'd4;
  localparam logic [2:0] OP_NS_EOI_ROT = 3'd5;
  localparam logic [2:0] OP_SET_BASE   = 3'd6;
  localparam logic [2:0] OP_SP_EOI_ROT = 3'd7;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irqc_prio_find.sv
// Rotating priority search: rank p belongs to line (p + base) mod LINES.
module irqc_prio_find #(
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] req,
  input  logic [IDX_W-1:0] base,
  output logic             hit,
  output logic [IDX_W:0]   rank,
  output logic [IDX_W-1:0] line
);
  always_comb begin
    hit  = 1'b0;
    rank = (IDX_W+1)'(LINES);
    line = '0;
    for (int p = LINES - 1; p >= 0; p--) begin
      if (req[(p + int'(base)) % LINES]) begin
        hit  = 1'b1;
        rank = (IDX_W+1)'(p);
        line = IDX_W'((p + int'(base)) % LINES);
      end
    end
  end
endmodule

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_in,
  input  logic [LINES-1:0] lvl_mode,
  input  logic [LINES-1:0] clr,
  input  logic             wipe,
  output logic [LINES-1:0] irr
);
  logic [LINES-1:0] last_q, irr_n, last_n;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sampled;
    assign sampled   = lvl_mode[i] ? lines_in[i]
                                   : (lines_in[i] & (irr[i] | ~last_q[i]));
    assign irr_n[i]  = wipe ? 1'b0 : (sampled & ~clr[i]);
    assign last_n[i] = wipe ? 1'b0 : lines_in[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr    <= '0;
      last_q <= '0;
    end else begin
      irr    <= irr_n;
      last_q <= last_n;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int LINES     = 8,
  parameter bit IS_MASTER = 1'b1,
  parameter int CASC_LINE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_lines,
  input  logic [LINES-1:0] lvl_mode,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             ack,
  output logic [7:0]       vec_out,
  output logic             int_out
);
  import irqc_pkg::*;
  localparam int IDX_W = $clog2(LINES);

  logic rst_sync_n;
  irqc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // state registers and next values
  logic [LINES-1:0] imr, isr, imr_n, isr_n, irr, irr_clr;
  logic [IDX_W-1:0] base, base_n;
  logic [7:0]       vbase, vbase_n;
  seq_e             seq, seq_n;
  logic need4, sfnm, aeoi, rot_aeoi, rsel, poll, smask;
  logic need4_n, sfnm_n, aeoi_n, rot_aeoi_n, rsel_n, poll_n, smask_n;

  // priority searches
  logic [LINES-1:0] pend, cur_req, casc_ign;
  logic             p_hit, c_hit, r_hit;
  logic [IDX_W:0]   p_rank, c_rank, r_rank;
  logic [IDX_W-1:0] p_line, c_line, r_line;

  assign pend     = irr & ~imr;
  assign casc_ign = (IS_MASTER && sfnm) ? LINES'(1) << CASC_LINE : '0;
  assign cur_req  = isr & ~casc_ign & ~(smask ? imr : '0);

  irqc_prio_find #(.LINES(LINES)) u_pend (
    .req(pend), .base(base), .hit(p_hit), .rank(p_rank), .line(p_line));
  irqc_prio_find #(.LINES(LINES)) u_cur (
    .req(cur_req), .base(base), .hit(c_hit), .rank(c_rank), .line(c_line));
  irqc_prio_find #(.LINES(LINES)) u_raw (
    .req(isr), .base(base), .hit(r_hit), .rank(r_rank), .line(r_line));

  assign int_out = p_hit && (p_rank < c_rank);

  logic take_ack, take_poll, init_wr;
  assign take_ack  = ack && int_out;
  assign take_poll = rd_en && poll && int_out;
  assign init_wr   = wr_en && !addr && wdata[4];
  assign irr_clr   = ((take_ack ? (LINES'(1) << p_line) : '0) & ~lvl_mode)
                   | (take_poll ? (LINES'(1) << p_line) : '0);

  irqc_req_latch #(.LINES(LINES)) u_req (
    .clk(clk), .rst_n(rst_sync_n), .lines_in(irq_lines), .lvl_mode(lvl_mode),
    .clr(irr_clr), .wipe(init_wr), .irr(irr));

  // outputs
  logic [IDX_W-1:0] vec_line;
  assign vec_line = int_out ? p_line : IDX_W'(LINES - 1);
  assign vec_out  = vbase | 8'(vec_line);

  always_comb begin
    if (poll)      rdata = int_out ? 8'(p_line) : 8'h00;
    else if (addr) rdata = 8'(imr);
    else if (rsel) rdata = 8'(isr);
    else           rdata = 8'(irr);
  end

  // next-state logic
  always_comb begin
    imr_n = imr;  isr_n = isr;  base_n = base;  vbase_n = vbase;  seq_n = seq;
    need4_n = need4;  sfnm_n = sfnm;  aeoi_n = aeoi;  rot_aeoi_n = rot_aeoi;
    rsel_n = rsel;  poll_n = poll;  smask_n = smask;

    if (take_ack) begin
      if (!aeoi)         isr_n[p_line] = 1'b1;
      else if (rot_aeoi) base_n = p_line + 1'b1;
    end

    if (rd_en && poll) begin
      poll_n = 1'b0;
      if (int_out) isr_n[p_line] = 1'b0;
    end

    if (wr_en && !addr) begin
      if (wdata[4]) begin
        imr_n = '0;  isr_n = '0;  base_n = '0;  vbase_n = '0;
        rsel_n = 1'b0;  poll_n = 1'b0;  smask_n = 1'b0;
        sfnm_n = 1'b0;  aeoi_n = 1'b0;  rot_aeoi_n = 1'b0;
        need4_n = wdata[0];
        seq_n = SEQ_BASE;
      end else if (wdata[3]) begin
        if (wdata[2]) poll_n = 1'b1;
        if (wdata[1]) rsel_n = wdata[0];
        if (wdata[6]) smask_n = wdata[5];
      end else begin
        unique case (wdata[7:5])
          OP_ROT_AEOI_A, OP_ROT_AEOI_B: rot_aeoi_n = wdata[7];
          OP_NS_EOI, OP_NS_EOI_ROT: begin
            if (r_hit) begin
              isr_n[r_line] = 1'b0;
              if (wdata[7]) base_n = r_line + 1'b1;
            end
          end
          OP_SP_EOI, OP_SP_EOI_ROT: begin
            isr_n[wdata[IDX_W-1:0]] = 1'b0;
            if (wdata[7]) base_n = wdata[IDX_W-1:0] + 1'b1;
          end
          OP_SET_BASE: base_n = wdata[IDX_W-1:0] + 1'b1;
          default: ;
        endcase
      end
    end else if (wr_en && addr) begin
      unique case (seq)
        SEQ_RUN:  imr_n = wdata[LINES-1:0];
        SEQ_BASE: begin
          vbase_n = {wdata[7:IDX_W], IDX_W'(0)};
          seq_n   = SEQ_CASC;
        end
        SEQ_CASC: seq_n = need4 ? SEQ_MODE : SEQ_RUN;
        SEQ_MODE: begin
          sfnm_n = wdata[4];
          aeoi_n = wdata[1];
          seq_n  = SEQ_RUN;
        end
        default: seq_n = SEQ_RUN;
      endcase
    end
  end

  logic upd_en;
  assign upd_en = wr_en | rd_en | ack;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      imr <= '0;  isr <= '0;  base <= '0;  vbase <= '0;  seq <= SEQ_RUN;
      need4 <= 1'b0;  sfnm <= 1'b0;  aeoi <= 1'b0;  rot_aeoi <= 1'b0;
      rsel <= 1'b0;  poll <= 1'b0;  smask <= 1'b0;
    end else if (upd_en) begin
      imr <= imr_n;  isr <= isr_n;  base <= base_n;  vbase <= vbase_n;  seq <= seq_n;
      need4 <= need4_n;  sfnm <= sfnm_n;  aeoi <= aeoi_n;  rot_aeoi <= rot_aeoi_n;
      rsel <= rsel_n;  poll <= poll_n;  smask <= smask_n;
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic             addr,
  input logic [7:0]       wdata,
  input logic             ack,
  input logic             int_out,
  input logic [7:0]       vec_out,
  input logic             poll,
  input logic             aeoi,
  input logic [1:0]       seq,
  input logic [LINES-1:0] imr,
  input logic [LINES-1:0] isr,
  input logic [LINES-1:0] irr
);
  // R3
  init_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (isr == '0 && imr == '0 && !int_out));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && seq == 2'd0) |=> (imr == $past(wdata[LINES-1:0])));

  // R8
  ack_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !aeoi && !wr_en && !rd_en) |=> isr[$past(vec_out[IDX_W-1:0])]);

  // R12
  poll_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll && !wr_en) |=> !poll);

  // R2
  int_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != '0));
endmodule

bind irq_prio_ctrl irqc_chk #(.LINES(LINES)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .ack(ack), .int_out(int_out), .vec_out(vec_out), .poll(poll),
  .aeoi(aeoi), .seq(seq), .imr(imr), .isr(isr), .irr(irr));

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_lines = 8'h00;
  logic [7:0] lvl_mode = 8'hFF;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, vec_out;
  logic       int_out;
  int         checks = 0;
  int         errors = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .lvl_mode(lvl_mode),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ack(ack), .vec_out(vec_out), .int_out(int_out));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack = 1'b1; #1 v = vec_out;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_lines = v;
    @(negedge clk);
  endtask

  function automatic int exp_line(input int pat, input int off);
    for (int p = 0; p < 8; p++)
      if (pat[(p + off) % 8]) return (p + off) % 8;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(1'b1, got); chk("R7 reset mask", got, 0);
    rd(1'b0, got); chk("R7 reset request", got, 0);
    chk("R2 reset int", int_out, 0);

    // four-byte init, base 0x40, no modes
    wr(0, 8'h11); wr(1, 8'h47); wr(1, 8'h00); wr(1, 8'h00);

    // R6 masking
    wr(1, 8'hFF); set_irq(8'h01); @(negedge clk);
    chk("R6 masked no int", int_out, 0);
    rd(1'b1, got); chk("R6 mask readback", got, 8'hFF);
    wr(1, 8'h00); chk("R6 unmasked int", int_out, 1);
    set_irq(8'h00); @(negedge clk);

    // sweep over all bases and request patterns (level lines)
    wr(0, 8'h0B);
    for (int off = 0; off < 8; off++) begin
      wr(0, 8'hC0 | 8'((off + 7) % 8));
      for (int pat = 1; pat < 256; pat++) begin
        int e;
        e = exp_line(pat, off);
        set_irq(8'(pat));
        chk("R1 int raised", int_out, 1);
        do_ack(got);
        chk("R1 R4 vector", got, 8'h40 | 8'(e));
        chk("R2 no int at equal rank", int_out, 0);
        rd(1'b0, got); chk("R8 in-service set", got, 1 << e);
        wr(0, 8'h60 | 8'(e));
        rd(1'b0, got); chk("R10 specific EOI", got, 0);
      end
    end
    wr(0, 8'hC7);

    // nesting, non-specific and rotating EOI
    set_irq(8'h20); do_ack(got); chk("R1 vec line5", got, 8'h45);
    set_irq(8'hA0); chk("R2 lower blocked", int_out, 0);
    set_irq(8'h28); chk("R2 higher preempts", int_out, 1);
    do_ack(got); chk("R1 vec line3", got, 8'h43);
    rd(1'b0, got); chk("R8 nested isr", got, 8'h28);
    wr(0, 8'h20); rd(1'b0, got); chk("R9 non-specific EOI", got, 8'h20);
    wr(0, 8'hA0); rd(1'b0, got); chk("R9 rotating EOI clears", got, 0);
    set_irq(8'h81); do_ack(got); chk("R9 base now 6", got, 8'h47);
    wr(0, 8'hE7); rd(1'b0, got); chk("R10 rotate specific EOI", got, 0);
    do_ack(got); chk("R10 base now 0", got, 8'h40);
    wr(0, 8'h60); set_irq(8'h00);

    // level line keeps its request after acknowledge
    wr(0, 8'h0A); set_irq(8'h10);
    do_ack(got); chk("R8 vec line4", got, 8'h44);
    rd(1'b0, got); chk("R8 level request kept", got, 8'h10);
    wr(0, 8'h64); set_irq(8'h00);

    // edge lines
    lvl_mode = 8'h00; set_irq(8'h00);
    set_irq(8'h04); rd(1'b0, got); chk("R14 edge latched", got, 8'h04);
    do_ack(got); chk("R4 vec line2", got, 8'h42);
    rd(1'b0, got); chk("R8 edge request cleared", got, 0);
    wr(0, 8'h62);
    set_irq(8'h04); rd(1'b0, got); chk("R14 held high no retrigger", got, 0);
    set_irq(8'h00); set_irq(8'h04); rd(1'b0, got); chk("R14 new edge", got, 8'h04);
    set_irq(8'h00); rd(1'b0, got); chk("R14 low clears", got, 0);

    // poll
    set_irq(8'h40); wr(0, 8'h0C);
    rd(1'b0, got); chk("R12 poll line", got, 6);
    rd(1'b0, got); chk("R12 poll disarmed, request cleared", got, 0);
    wr(0, 8'h0C); set_irq(8'h00);
    rd(1'b0, got); chk("R12 poll empty", got, 0);
    rd(1'b1, got); chk("R7 mask after poll", got, 0);

    // three-byte init and base truncation
    wr(1, 8'h55); rd(1'b1, got); chk("R7 mask readback", got, 8'h55);
    wr(0, 8'h10); wr(1, 8'h2F); wr(1, 8'h00);
    wr(1, 8'hF0); rd(1'b1, got); chk("R5 three-byte init ends", got, 8'hF0);
    wr(1, 8'h00);
    set_irq(8'h02); do_ack(got); chk("R4 base low bits cleared", got, 8'h29);
    wr(0, 8'h0B); rd(1'b0, got); chk("R11 normal ack sets isr", got, 8'h02);
    wr(0, 8'h20); set_irq(8'h00);

    // auto-EOI with rotation
    wr(1, 8'h55);
    wr(0, 8'h11); wr(1, 8'h80); wr(1, 8'h00); wr(1, 8'h02);
    rd(1'b1, got); chk("R3 init cleared mask", got, 0);
    wr(0, 8'h80);
    set_irq(8'h08); do_ack(got); chk("R11 vec line3", got, 8'h83);
    wr(0, 8'h0B); rd(1'b0, got); chk("R11 no isr in auto-EOI", got, 0);
    set_irq(8'h00); set_irq(8'h11);
    do_ack(got); chk("R11 rotated base picks line4", got, 8'h84);
    do_ack(got); chk("R11 then line0", got, 8'h80);
    set_irq(8'h00);

    // special fully nested and special mask (level lines)
    lvl_mode = 8'hFF;
    wr(0, 8'h11); chk("R3 init drops int", int_out, 0);
    wr(1, 8'h08); wr(1, 8'h00); wr(1, 8'h10);
    set_irq(8'h04); do_ack(got); chk("R13 vec line2", got, 8'h0A);
    chk("R13 cascade isr ignored", int_out, 1);
    wr(0, 8'h62);
    set_irq(8'h02); do_ack(got); chk("R13 vec line1", got, 8'h09);
    set_irq(8'h06); chk("R13 line2 blocked by line1", int_out, 0);
    wr(0, 8'h68); wr(1, 8'h02); chk("R13 special mask frees line2", int_out, 1);
    wr(0, 8'h48); chk("R13 special mask off", int_out, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule